// File: doc/BRIEF.md
# All-Pairs Ring Oscillator Response Generator

This block turns one challenge into a multi-bit physical unclonable response. It does this by racing a bank of external ring oscillator arrays against each other. When a start strobe arrives, the block captures the challenge. The challenge holds a delay-stage configuration word and a ring-select field. The block drives both fields unchanged to every array, so the rings in any compared pair run under exactly the same setting. With that setting, only manufacturing spread separates one ring from another.

The block then clears one edge counter per ring and enables all rings for a fixed number of system clock cycles. Each ring's output passes through a two-flop synchronizer with rising-edge detection, and its edges are counted in the system clock domain. After the window closes, the rings are switched off. A pair walker then visits every unordered pair (i, j) with i < j, one pair per cycle, and shifts one comparison bit into the response register. With the default 15 rings, one run produces 105 bits.

A busy/done handshake frames each run. A sticky flag reports that at least one pair produced equal counts, which marks the response as less trustworthy.

Top module: `apro_top`

## Requirements
- R1: Bit k of `response` (bit 0 first) belongs to the k-th pair when pairs are listed with i ascending in the outer loop and j ascending from i+1 in the inner loop. The bit is 1 exactly when ring i counted more rising edges than ring j, so with stable rings, a faster ring i gives 1.
- R2: A pair with equal counts yields bit 0 and sets `tie_flag`. The flag stays set until the next accepted start, which clears it. A run with no equal pair ends with `tie_flag` at 0.
- R3: The configuration and select fields of an accepted start appear on `ring_cfg` and `ring_sel` from the cycle after the start. They stay constant until the next accepted start.
- R4: `ring_en` is high for exactly `GATE_CYCLES` consecutive system cycles per run. It is low while pairs are compared and when `done` pulses.
- R5: `busy` is high from the cycle after an accepted start until the comparison of the last pair. `done` is high for exactly one cycle after that, while `busy` is low. Every accepted start produces exactly one `done`.
- R6: A `start` raised while `busy` is high is ignored. The run in progress keeps its configuration, its response and its single `done`.
- R7: A `start` raised in the same cycle as `done` is accepted and begins a new run.
- R8: After reset, `busy`, `done`, `ring_en`, `tie_flag` and `response` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start strobe, sampled when idle or in the done cycle |
| chal_cfg | input | CFG_W | Delay-stage configuration part of the challenge |
| chal_sel | input | SEL_W | Ring-select part of the challenge |
| ring_clk | input | N_RINGS | Oscillator outputs, one per array, asynchronous |
| ring_en | output | 1 | Enable for all rings during the gate window |
| ring_cfg | output | CFG_W | Captured configuration, shared by all arrays |
| ring_sel | output | SEL_W | Captured ring-select field |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| response | output | N_RINGS*(N_RINGS-1)/2 | Collected comparison bits |
| tie_flag | output | 1 | Sticky: some pair had equal counts in this run |

## Verification
Two functions can coincide: the end-of-run `done` pulse and acceptance of the next `start`. The bench watches for `done` and raises `start` with a new challenge during that same cycle. It then expects `busy` on the next sample, a new challenge on `ring_cfg`, and a second scoreboard entry that later matches. A second case places a start strobe in the middle of the gate window. That run must finish with its own configuration and a single `done`.

// File: rtl/apro_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the all-pairs ring response generator.
// Assumes nothing beyond a synthesizable enum.
package apro_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CLEAR = 3'd1,
        ST_GATE  = 3'd2,
        ST_CMP   = 3'd3,
        ST_DONE  = 3'd4
    } apro_state_e;

    // Number of unordered pairs among n rings.
    function automatic int pair_total(input int n);
        return (n * (n - 1)) / 2;
    endfunction

endpackage

// File: rtl/apro_edge_cnt.sv
`timescale 1ns/1ps
// Brings one asynchronous ring output into the system clock domain and
// counts its rising edges. The count saturates at all-ones.
// Assumes each ring level lasts longer than one system clock period.
module apro_edge_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ring_clk,
    input  logic             clr,
    input  logic             cnt_en,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [2:0]       sync_q;
    logic             rise;
    logic [CNT_W-1:0] cnt_q;

    // Two synchronizing flops plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], ring_clk};
    end

    assign rise = sync_q[1] & ~sync_q[2];

    // Edge counter: clear on request, count while enabled, hold at maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)                               cnt_q <= '0;
        else if (clr)                             cnt_q <= '0;
        else if (cnt_en && rise && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !clr) |=> (cnt_q == CNT_MAX)); // R1

endmodule

// File: rtl/apro_pair_seq.sv
`timescale 1ns/1ps
// Walks every unordered ring pair (i, j), i < j, in lexicographic order,
// one pair per step. Flags the final pair (N-2, N-1).
// Assumes N_RINGS >= 2.
module apro_pair_seq #(
    parameter int N_RINGS = 15,
    parameter int IDX_W   = $clog2(N_RINGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    output logic [IDX_W-1:0] idx_i,
    output logic [IDX_W-1:0] idx_j,
    output logic             last
);

    localparam logic [IDX_W-1:0] TOP_J = IDX_W'(N_RINGS - 1);
    localparam logic [IDX_W-1:0] TOP_I = IDX_W'(N_RINGS - 2);

    logic [IDX_W-1:0] i_q, j_q;

    // Pair registers: restart at (0,1), wrap j back above the next i.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            i_q <= '0;
            j_q <= IDX_W'(1);
        end else if (step && !last) begin
            if (j_q == TOP_J) begin
                i_q <= i_q + 1'b1;
                j_q <= i_q + IDX_W'(2);
            end else begin
                j_q <= j_q + 1'b1;
            end
        end
    end

    assign idx_i = i_q;
    assign idx_j = j_q;
    assign last  = (i_q == TOP_I) && (j_q == TOP_J);

    AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (i_q < j_q) && (j_q <= TOP_J)); // R1

endmodule

// File: rtl/apro_top.sv
`timescale 1ns/1ps
// All-pairs ring oscillator response generator. Captures a challenge,
// runs all rings for a fixed gate window, then compares every pair of
// counts and shifts one bit per pair into the response register.
// Assumes GATE_CYCLES >= 1 and rings that stop when ring_en is low.
module apro_top
    import apro_pkg::*;
#(
    parameter int N_RINGS     = 15,
    parameter int CFG_W       = 15,
    parameter int SEL_W       = 4,
    parameter int CNT_W       = 16,
    parameter int GATE_CYCLES = 200,
    parameter int NPAIRS      = (N_RINGS * (N_RINGS - 1)) / 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [CFG_W-1:0]    chal_cfg,
    input  logic [SEL_W-1:0]    chal_sel,
    input  logic [N_RINGS-1:0]  ring_clk,
    output logic                ring_en,
    output logic [CFG_W-1:0]    ring_cfg,
    output logic [SEL_W-1:0]    ring_sel,
    output logic                busy,
    output logic                done,
    output logic [NPAIRS-1:0]   response,
    output logic                tie_flag
);

    localparam int IDX_W  = (N_RINGS > 2) ? $clog2(N_RINGS) : 1;
    localparam int GATE_W = $clog2(GATE_CYCLES + 1);
    localparam logic [GATE_W-1:0] GATE_LOAD = GATE_W'(GATE_CYCLES - 1);

    apro_state_e        state_q, state_d;
    logic               accept;
    logic [GATE_W-1:0]  gate_q;
    logic [CFG_W-1:0]   cfg_q;
    logic [SEL_W-1:0]   sel_q;
    logic [NPAIRS-1:0]  resp_q;
    logic               tie_q;
    logic               cnt_clr, cnt_en;
    logic [IDX_W-1:0]   idx_i, idx_j;
    logic               last_pair;
    logic [CNT_W-1:0]   counts [N_RINGS];
    logic [CNT_W-1:0]   cnt_a, cnt_b;
    logic               pair_bit, pair_tie;

    assign accept = start && (state_q == ST_IDLE || state_q == ST_DONE);

    // Next-state selection for the run sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_CLEAR;
            ST_CLEAR: state_d = ST_GATE;
            ST_GATE:  if (gate_q == '0) state_d = ST_CMP;
            ST_CMP:   if (last_pair) state_d = ST_DONE;
            ST_DONE:  state_d = accept ? ST_CLEAR : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Challenge capture on an accepted start only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            sel_q <= '0;
        end else if (accept) begin
            cfg_q <= chal_cfg;
            sel_q <= chal_sel;
        end
    end

    // Gate window timer: loaded while clearing, counts down while rings run.
    always_ff @(posedge clk) begin
        if (!rst_n)                    gate_q <= '0;
        else if (state_q == ST_CLEAR)  gate_q <= GATE_LOAD;
        else if (state_q == ST_GATE && gate_q != '0) gate_q <= gate_q - 1'b1;
    end

    assign cnt_clr = (state_q == ST_CLEAR);
    assign cnt_en  = (state_q == ST_GATE);

    // One synchronizer and counter per ring.
    for (genvar g = 0; g < N_RINGS; g++) begin : g_ring
        apro_edge_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .ring_clk (ring_clk[g]),
            .clr      (cnt_clr),
            .cnt_en   (cnt_en),
            .count    (counts[g])
        );
    end

    apro_pair_seq #(.N_RINGS(N_RINGS), .IDX_W(IDX_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cnt_clr),
        .step  (state_q == ST_CMP),
        .idx_i (idx_i),
        .idx_j (idx_j),
        .last  (last_pair)
    );

    assign cnt_a    = counts[idx_i];
    assign cnt_b    = counts[idx_j];
    assign pair_bit = (cnt_a > cnt_b);
    assign pair_tie = (cnt_a == cnt_b);

    // Response shift register: new bit enters at the top, first pair ends at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ST_CLEAR) resp_q <= '0;
        else if (state_q == ST_CMP)        resp_q <= {pair_bit, resp_q[NPAIRS-1:1]};
    end

    // Sticky tie flag, cleared at the start of each run.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ST_CLEAR)  tie_q <= 1'b0;
        else if (state_q == ST_CMP && pair_tie) tie_q <= 1'b1;
    end

    assign ring_en  = (state_q == ST_GATE);
    assign ring_cfg = cfg_q;
    assign ring_sel = sel_q;
    assign busy     = (state_q == ST_CLEAR) || (state_q == ST_GATE) || (state_q == ST_CMP);
    assign done     = (state_q == ST_DONE);
    assign response = resp_q;
    assign tie_flag = tie_q;

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(ring_cfg) && $stable(ring_sel))); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done)); // R6
    AST_TIE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tie_flag && !busy && !start) |=> tie_flag); // R2
    AST_EN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ring_en); // R4

endmodule

// File: tb/tb_apro_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected results, the monitor pops them at done.
module tb_apro_top;

    localparam int CLK_PERIOD = 10;
    localparam int N      = 15;
    localparam int CFG_W  = 15;
    localparam int SEL_W  = 4;
    localparam int GATE   = 200;
    localparam int NP     = (N * (N - 1)) / 2;

    typedef struct packed {
        logic [NP-1:0]    resp;
        logic             tie;
        logic [CFG_W-1:0] cfg;
        logic [SEL_W-1:0] sel;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CFG_W-1:0] chal_cfg = '0;
    logic [SEL_W-1:0] chal_sel = '0;
    logic [N-1:0]     ring_clk;
    logic             ring_en;
    logic [CFG_W-1:0] ring_cfg;
    logic [SEL_W-1:0] ring_sel;
    logic             busy, done, tie_flag;
    logic [NP-1:0]    response;

    int   hp [N];
    int   n_checks = 0;
    int   n_fail = 0;
    int   n_pushed = 0;
    int   n_done = 0;
    int   en_cycles = 0;
    exp_t sb_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    apro_top dut (
        .clk(clk), .rst_n(rst_n), .start(start), .chal_cfg(chal_cfg),
        .chal_sel(chal_sel), .ring_clk(ring_clk), .ring_en(ring_en),
        .ring_cfg(ring_cfg), .ring_sel(ring_sel), .busy(busy), .done(done),
        .response(response), .tie_flag(tie_flag)
    );

    // Behavioural ring models: fixed half-period, idle low while disabled.
    for (genvar g = 0; g < N; g++) begin : g_osc
        logic r = 1'b0;
        initial begin
            forever begin
                @(posedge ring_en);
                while (ring_en) begin
                    #(hp[g]);
                    r = ~r;
                end
                r = 1'b0;
            end
        end
        assign ring_clk[g] = r;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Half-periods chosen so edge counts differ by at least three.
    function automatic int speed(input int r);
        int tbl [15] = '{12, 13, 14, 15, 16, 17, 18, 19, 21, 23, 25, 28, 31, 35, 40};
        return tbl[r];
    endfunction

    function automatic exp_t model(input logic [CFG_W-1:0] c, input logic [SEL_W-1:0] s);
        exp_t e;
        int k = 0;
        e.resp = '0;
        e.tie  = 1'b0;
        e.cfg  = c;
        e.sel  = s;
        for (int i = 0; i < N - 1; i++) begin
            for (int j = i + 1; j < N; j++) begin
                e.resp[k] = (hp[i] < hp[j]);
                if (hp[i] == hp[j]) e.tie = 1'b1;
                k++;
            end
        end
        return e;
    endfunction

    task automatic launch(input logic [CFG_W-1:0] c, input logic [SEL_W-1:0] s);
        chal_cfg = c;
        chal_sel = s;
        start    = 1'b1;
        sb_q.push_back(model(c, s));
        n_pushed++;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R5", "busy after start", 128'(busy), 128'(1));
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic run(input logic [CFG_W-1:0] c, input logic [SEL_W-1:0] s);
        @(negedge clk);
        launch(c, s);
        wait_done();
        @(negedge clk);
    endtask

    // Monitor: gate length, handshake, and scoreboard comparison at done.
    always @(negedge clk) begin
        if (rst_n) begin
            if (ring_en) en_cycles++;
            if (done) begin
                exp_t e;
                n_done++;
                check(en_cycles == GATE, "R4", "gate cycles", 128'(en_cycles), 128'(GATE));
                check(ring_en == 1'b0, "R4", "ring_en at done", 128'(ring_en), 128'(0));
                check(busy == 1'b0, "R5", "busy at done", 128'(busy), 128'(0));
                en_cycles = 0;
                if (sb_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected done", 128'(n_done), 128'(n_pushed));
                end else begin
                    e = sb_q.pop_front();
                    check(response == e.resp, "R1", "response", 128'(response), 128'(e.resp));
                    check(tie_flag == e.tie, "R2", "tie flag", 128'(tie_flag), 128'(e.tie));
                    check(ring_cfg == e.cfg, "R3", "ring_cfg", 128'(ring_cfg), 128'(e.cfg));
                    check(ring_sel == e.sel, "R3", "ring_sel", 128'(ring_sel), 128'(e.sel));
                end
            end else if (done === 1'b0 && $time > 0) begin
                // nothing between done pulses
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int r = 0; r < N; r++) hp[r] = speed(r);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        check(busy == 1'b0, "R8", "busy", 128'(busy), 128'(0));
        check(done == 1'b0, "R8", "done", 128'(done), 128'(0));
        check(ring_en == 1'b0, "R8", "ring_en", 128'(ring_en), 128'(0));
        check(tie_flag == 1'b0, "R8", "tie_flag", 128'(tie_flag), 128'(0));
        check(response == '0, "R8", "response", 128'(response), 128'(0));

        // R1: ascending speeds -> ring i always faster -> all ones
        run(15'h1A5C, 4'h3);
        // R1: reversed speeds -> all zeros
        for (int r = 0; r < N; r++) hp[r] = speed(N - 1 - r);
        run(15'h7FFF, 4'hF);
        // R1: scrambled speed order
        for (int r = 0; r < N; r++) hp[r] = speed((r * 7) % N);
        run(15'h0001, 4'h0);

        // R2: equal rings in the middle, then at the first and last positions
        for (int r = 0; r < N; r++) hp[r] = speed((r * 4) % N);
        hp[9] = hp[3];
        run(15'h2222, 4'h5);
        for (int r = 0; r < N; r++) hp[r] = speed(r);
        hp[14] = hp[13];
        hp[0]  = hp[1];
        run(15'h5555, 4'hA);
        // R2: next run without ties clears the flag
        for (int r = 0; r < N; r++) hp[r] = speed((r * 11) % N);
        run(15'h3C3C, 4'h6);

        // R6: start during the gate window is ignored
        @(negedge clk);
        launch(15'h0F0F, 4'h9);
        repeat (50) @(negedge clk);
        chal_cfg = 15'h7000;
        chal_sel = 4'h1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(ring_cfg == 15'h0F0F, "R6", "cfg after ignored start", 128'(ring_cfg), 128'(15'h0F0F));
        wait_done();

        // R7: start in the done cycle is accepted
        launch(15'h1234, 4'hC);
        check(ring_cfg == 15'h1234, "R7", "new cfg captured", 128'(ring_cfg), 128'(15'h1234));
        wait_done();
        @(negedge clk);
        repeat (5) @(negedge clk);

        check(sb_q.size() == 0, "R5", "pending results", 128'(sb_q.size()), 128'(0));
        check(n_done == n_pushed, "R6", "done count", 128'(n_done), 128'(n_pushed));
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule